// File: doc/BRIEF.md
# Receive Filter Rule Table

This block stores the rule set for a receive-side packet filer: 256 rules, each made of a 32-bit control word and a 32-bit property word. Software never sees the rules as a flat memory. It first writes a rule number into an index register. It then reads or writes the chosen rule's control word through one data window and the property word through a second data window. All three windows sit on a small word-addressed register bus that carries write and read strobes.

A second port, which only reads, serves the matching engine. It takes a rule number every cycle and returns both words of that rule one cycle later. This port does not depend on the software index. Each word array is a one-write, two-read memory, so it maps onto a block RAM.

Top module: `filer_rule_table`

## Requirements
- R1: Each of the 256 entries stores a 32-bit control word and a 32-bit property word independently. A write to one word of an entry leaves its other word and all other entries unchanged.
- R2: The index register sits at bus word address 0. Its 8-bit rule number occupies bits 7:0, and it reads as zero after a synchronous reset.
- R3: Bits 31:8 of the index register always read as zero. Writes to those bits are discarded, and reading the register returns the current rule number in bits 7:0.
- R4: A write to word address 1 stores bus_wdata into the control word of the entry named by the index. A write to word address 2 stores it into that entry's property word.
- R5: A read strobe at address 0, 1 or 2 places the selected value on bus_rdata in the cycle after the strobe. bus_rdata then holds that value until the next read strobe, even if the word is written in the meantime.
- R6: The index changes only when word address 0 is written. Repeated data-window accesses do not advance it.
- R7: A data access in the cycle right after an index write already uses the new rule number.
- R8: The lookup port returns the control word on lk_ctl and the property word on lk_prop for entry lk_idx in the following cycle, whatever the software index holds.
- R9: When a lookup and a software write hit the same word of the same entry in one cycle, the lookup returns the contents from before the write. A lookup in the next cycle returns the new value.
- R10: Word addresses 3 to 15 read as zero. Writes to them change neither the index nor any entry.
- R11: When bus_wr and bus_rd are both high in one cycle, the write is performed and the read strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| lk_idx | input | 8 | Rule number requested by the matching engine |
| lk_ctl | output | 32 | Control word of the rule requested one cycle earlier |
| lk_prop | output | 32 | Property word of the rule requested one cycle earlier |

## Verification
Two operations can land on the same storage in one cycle. One is a software write through a data window. The other is an engine lookup of the same rule. The bench drives both strobes at the same falling edge and expects the lookup to return the old word, then issues a lookup in the next cycle and expects the new word. It also issues a software read and an engine lookup of different rules together, and checks that the two ports do not disturb each other. Each returned value is compared with the bench's own copy of the table.

// File: rtl/filer_tbl_pkg.sv
package filer_tbl_pkg;
  // bus word addresses of the three windows
  localparam int unsigned ADDR_INDEX = 0;
  localparam int unsigned ADDR_CTL   = 1;
  localparam int unsigned ADDR_PROP  = 2;

  // number of word arrays per entry (control, property)
  localparam int unsigned WORDS_PER_ENTRY = 2;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_IDX  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_PROP = 2'd3
  } win_sel_e;
endpackage

// File: rtl/filer_reg_decode.sv
module filer_reg_decode
  import filer_tbl_pkg::*;
#(
  parameter int unsigned BUS_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              idx_we,
  output logic              ctl_we,
  output logic              prop_we,
  output logic              ctl_re,
  output logic              prop_re,
  output logic              rd_go,
  output win_sel_e          rd_sel
);
  logic hit_idx, hit_ctl, hit_prop;

  always_comb begin
    hit_idx  = (bus_addr == BUS_AW'(ADDR_INDEX));
    hit_ctl  = (bus_addr == BUS_AW'(ADDR_CTL));
    hit_prop = (bus_addr == BUS_AW'(ADDR_PROP));
    // a write wins over a read in the same cycle
    rd_go    = bus_rd & ~bus_wr;
    idx_we   = bus_wr & hit_idx;
    ctl_we   = bus_wr & hit_ctl;
    prop_we  = bus_wr & hit_prop;
    ctl_re   = rd_go & hit_ctl;
    prop_re  = rd_go & hit_prop;
    if (hit_idx)       rd_sel = SEL_IDX;
    else if (hit_ctl)  rd_sel = SEL_CTL;
    else if (hit_prop) rd_sel = SEL_PROP;
    else               rd_sel = SEL_NONE;
  end

  // at most one window is written per cycle (R4, R10)
  assert_single_target_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({idx_we, ctl_we, prop_we}));

  // a read strobe never opens an array read port during a write (R11)
  assert_write_wins_R11: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> !(ctl_re || prop_re));
endmodule

// File: rtl/filer_index_reg.sv
module filer_index_reg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [IDX_W-1:0]  idx
);
  always_ff @(posedge clk) begin
    if (rst)     idx <= '0;
    else if (we) idx <= wdata[IDX_W-1:0];
  end

  assert_idx_reset_R2: assert property (@(posedge clk)
    rst |=> idx == '0);

  assert_idx_load_R7: assert property (@(posedge clk) disable iff (rst)
    we |=> idx == $past(wdata[IDX_W-1:0]));

  assert_idx_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(idx));
endmodule

// File: rtl/filer_word_ram.sv
module filer_word_ram #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ENTRIES = 256,
  localparam int unsigned AW     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic              a_re,
  input  logic [AW-1:0]     a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_q,
  input  logic [AW-1:0]     b_addr,
  output logic [DATA_W-1:0] b_q
);
  logic [DATA_W-1:0] mem [ENTRIES];

  // read-first on both ports; no reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (a_re) a_q <= mem[a_addr];
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/filer_rule_table.sv
module filer_rule_table
  import filer_tbl_pkg::*;
#(
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned BUS_AW  = 4,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [DATA_W-1:0] lk_ctl,
  output logic [DATA_W-1:0] lk_prop
);
  logic       idx_we, ctl_we, prop_we, ctl_re, prop_re, rd_go;
  win_sel_e   rd_sel, sel_q;
  logic [IDX_W-1:0] idx, idx_snap;

  logic              arr_we [WORDS_PER_ENTRY];
  logic              arr_re [WORDS_PER_ENTRY];
  logic [DATA_W-1:0] arr_aq [WORDS_PER_ENTRY];
  logic [DATA_W-1:0] arr_bq [WORDS_PER_ENTRY];

  filer_reg_decode #(.BUS_AW(BUS_AW)) u_dec (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .idx_we(idx_we), .ctl_we(ctl_we), .prop_we(prop_we),
    .ctl_re(ctl_re), .prop_re(prop_re), .rd_go(rd_go), .rd_sel(rd_sel)
  );

  filer_index_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst(rst), .we(idx_we), .wdata(bus_wdata), .idx(idx)
  );

  assign arr_we[0] = ctl_we;
  assign arr_re[0] = ctl_re;
  assign arr_we[1] = prop_we;
  assign arr_re[1] = prop_re;

  for (genvar g = 0; g < WORDS_PER_ENTRY; g++) begin : g_arr
    filer_word_ram #(.DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_ram (
      .clk(clk), .a_we(arr_we[g]), .a_re(arr_re[g]), .a_addr(idx),
      .a_wdata(bus_wdata), .a_q(arr_aq[g]), .b_addr(lk_idx), .b_q(arr_bq[g])
    );
  end

  assign lk_ctl  = arr_bq[0];
  assign lk_prop = arr_bq[1];

  // remember which window the last read targeted
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= SEL_NONE;
      idx_snap <= '0;
    end else if (rd_go) begin
      sel_q <= rd_sel;
      if (rd_sel == SEL_IDX) idx_snap <= idx;
    end
  end

  always_comb begin
    unique case (sel_q)
      SEL_IDX:  bus_rdata = DATA_W'(idx_snap);
      SEL_CTL:  bus_rdata = arr_aq[0];
      SEL_PROP: bus_rdata = arr_aq[1];
      default:  bus_rdata = '0;
    endcase
  end

  assert_idx_readback_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_go && rd_sel == SEL_IDX) |=> bus_rdata == DATA_W'($past(idx)));

  assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !rd_go |=> $stable(bus_rdata));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_go && rd_sel == SEL_NONE) |=> bus_rdata == '0);
endmodule

// File: tb/test_filer_rule_table.sv
module test_filer_rule_table;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  lk_idx = '0;
  logic [31:0] lk_ctl, lk_prop;

  always #2 clk = ~clk; // 250 MHz

  filer_rule_table i_filer_rule_table (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lk_idx(lk_idx), .lk_ctl(lk_ctl), .lk_prop(lk_prop)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;

  logic [31:0] m_ctl [256];
  logic [31:0] m_prop [256];
  logic [7:0]  m_idx = '0;

  typedef struct { logic [63:0] v; string tag; } exp_t;
  exp_t rd_q[$];
  exp_t lk_q[$];
  logic lk_req = 1'b0, rd_seen = 1'b0, lk_seen = 1'b0;

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor
  always @(posedge clk) begin
    rd_seen <= bus_rd & ~bus_wr;
    lk_seen <= lk_req;
  end
  always @(negedge clk) begin
    if (rd_seen) begin
      exp_t e;
      if (rd_q.size() == 0) check(64'(bus_rdata), 64'hx, "R5 unexpected read");
      else begin e = rd_q.pop_front(); check(64'(bus_rdata), e.v, e.tag); end
    end
    if (lk_seen) begin
      exp_t e;
      if (lk_q.size() != 0) begin
        e = lk_q.pop_front();
        check({lk_ctl, lk_prop}, e.v, e.tag);
      end
    end
  end

  // driver tasks, each entered and left at a falling edge
  task automatic bwrite(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    if (a == 4'd0) m_idx = d[7:0];
    else if (a == 4'd1) m_ctl[m_idx] = d;
    else if (a == 4'd2) m_prop[m_idx] = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  function automatic logic [31:0] model_rd(input logic [3:0] a);
    if (a == 4'd0) return {24'h0, m_idx};
    if (a == 4'd1) return m_ctl[m_idx];
    if (a == 4'd2) return m_prop[m_idx];
    return 32'h0;
  endfunction

  task automatic bread(input logic [3:0] a, input string tag);
    exp_t e;
    e.v = 64'(model_rd(a)); e.tag = tag; rd_q.push_back(e);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic lookup(input logic [7:0] n, input string tag);
    exp_t e;
    e.v = {m_ctl[n], m_prop[n]}; e.tag = tag; lk_q.push_back(e);
    lk_idx = n; lk_req = 1'b1;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(64'(bus_rdata), 64'h0, "R2 rdata after reset");
    bread(4'd0, "R2 index resets to zero");

    // reserved bits of the index register
    bwrite(4'd0, 32'h1234_56A5);
    bread(4'd0, "R3 reserved bits read zero");

    // fill the whole table
    for (int i = 0; i < 256; i++) begin
      bwrite(4'd0, 32'(i));
      bwrite(4'd1, 32'hC000_0000 | (32'(i) << 8) | 32'(i[7:0] ^ 8'h5A));
      bwrite(4'd2, {i[7:0], ~i[7:0], 8'h3C, i[7:0]});
    end

    // read back everything through the windows
    for (int i = 0; i < 256; i++) begin
      bwrite(4'd0, 32'(i));      // R7 back-to-back index then data
      bread(4'd1, "R4 R7 control word readback");
      bread(4'd2, "R4 property word readback");
    end

    // no auto-increment
    bwrite(4'd0, 32'd7);
    bread(4'd1, "R6 ctl read 1");
    bread(4'd1, "R6 ctl read 2");
    bread(4'd2, "R6 prop read");
    bread(4'd0, "R6 index unchanged after data reads");

    // independence of the two words
    bwrite(4'd0, 32'd9);
    bwrite(4'd1, 32'hDEAD_0009);
    bread(4'd2, "R1 property untouched by control write");
    bread(4'd1, "R1 control updated");
    bwrite(4'd0, 32'd10);
    bread(4'd1, "R1 neighbour entry untouched");

    // hold of read data
    bread(4'd1, "R5 read of entry 10");
    bwrite(4'd1, 32'h7777_0010);
    @(negedge clk);
    check(64'(bus_rdata), 64'(32'hC000_0A00 | 32'(8'd10 ^ 8'h5A)), "R5 rdata held after write");

    // lookup port independent of software index
    lookup(8'd0, "R8 lookup entry 0");
    lookup(8'd255, "R8 lookup entry 255");
    lookup(8'd9, "R8 lookup entry 9");
    // software read and lookup together, different entries
    begin
      exp_t e;
      e.v = {m_ctl[8'd200], m_prop[8'd200]}; e.tag = "R8 lookup during software read";
      lk_q.push_back(e);
      e.v = 64'(m_ctl[m_idx]); e.tag = "R8 software read during lookup";
      rd_q.push_back(e);
      lk_idx = 8'd200; lk_req = 1'b1; bus_addr = 4'd1; bus_rd = 1'b1;
      @(negedge clk);
      lk_req = 1'b0; bus_rd = 1'b0;
    end

    // collision: lookup and write hit the same word in one cycle
    begin
      exp_t e;
      e.v = {m_ctl[m_idx], m_prop[m_idx]}; e.tag = "R9 lookup sees old word";
      lk_q.push_back(e);
      lk_idx = m_idx; lk_req = 1'b1;
      bus_addr = 4'd2; bus_wdata = 32'hABCD_1234; bus_wr = 1'b1;
      m_prop[m_idx] = 32'hABCD_1234;
      @(negedge clk);
      lk_req = 1'b0; bus_wr = 1'b0;
      lookup(m_idx, "R9 lookup sees new word");
    end

    // unmapped addresses
    bread(4'd5, "R10 unmapped reads zero");
    bwrite(4'd3, 32'hFFFF_FFFF);
    bwrite(4'd15, 32'h0000_0042);
    bread(4'd0, "R10 index unchanged by unmapped write");
    bread(4'd1, "R10 control unchanged by unmapped write");
    bread(4'd2, "R10 property unchanged by unmapped write");

    // write and read strobes together
    bread(4'd0, "R11 read before combined strobe");
    bus_addr = 4'd1; bus_wdata = 32'h5555_AAAA; bus_wr = 1'b1; bus_rd = 1'b1;
    m_ctl[m_idx] = 32'h5555_AAAA;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    @(negedge clk);
    check(64'(bus_rdata), 64'(m_idx), "R11 read ignored, rdata keeps index");
    bread(4'd1, "R11 write performed");

    repeat (3) @(negedge clk);
    if (rd_q.size() != 0 || lk_q.size() != 0) begin
      mismatched++;
      $display("FAIL R5: actual %0d pending results expected 0", rd_q.size() + lk_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule